// File: doc/BRIEF.md
# Code Prefetch Byte Queue

This unit sits on the bus side of a 16-bit processor. It fetches code ahead of the execution side, so that the next instruction bytes are already waiting when they are needed. Each fetch moves one 16-bit word over a request/acknowledge bus handshake. The returned bytes go into a six-entry byte queue. The execution side takes bytes from the head of the queue, one per cycle. The unit keeps its own 16-bit fetch offset and 16-bit code segment. It forms the 20-bit physical fetch address by shifting the segment left by four bits, adding the offset, and keeping the low 20 bits.

Fetching is controlled by a two-state machine. `FS_IDLE` is the state with no bus request pending. The transition *issue* (`FS_IDLE` to `FS_WAIT`) is taken when no redirect is present and at least two queue slots are free. `FS_WAIT` holds the request and its address steady. It leaves through *complete* (acknowledge seen, bytes written) or *cancel* (redirect seen, any returned data thrown away); both lead back to `FS_IDLE`. In `FS_IDLE`, a redirect just reloads the pointer and the machine stays in `FS_IDLE`. A redirect empties the queue and restarts fetching at a new segment and offset. A fetch from an odd offset keeps only the upper byte of the word, so every later fetch is word aligned.

Top module: `pfq_top`

## Requirements
- R1: While reset is held, `level` is 0, `byte_valid` is 0 and `bus_req` is 0. The first request after reset uses segment `RST_SEG` (default FFFF hex) and offset `RST_OFF` (default 0), which gives address FFFF0 hex.
- R2: `bus_addr` equals (segment × 16 + offset) modulo 2^20.
- R3: A new request is raised only when `level` is at most DEPTH−2 (default 4). `level` never exceeds DEPTH (default 6). A full queue, or a queue with one free slot, raises no request.
- R4: An acknowledge for an even offset writes two bytes to the queue: `bus_data[7:0]` first, then `bus_data[15:8]`. The offset then advances by 2.
- R5: An acknowledge for an odd offset writes only `bus_data[15:8]`. The offset then advances by 1, so the next fetch is at an even offset.
- R6: Once raised, `bus_req` stays high with a stable `bus_addr` until `bus_ack` or `flush`.
- R7: `byte_out` shows the oldest queued byte while `byte_valid` is high. Asserting `pop` then removes it, so bytes leave in ascending code-address order.
- R8: `pop` while the queue is empty has no effect. `byte_valid` stays low and `level` stays 0 until a fetch completes.
- R9: When a pop and a fill happen in the same cycle, `level` becomes level + bytes written − 1.
- R10: `flush` empties the queue by the next cycle and drops any pending request. A `bus_ack` in the same cycle as `flush` writes nothing. Fetching resumes at `flush_seg`/`flush_off`.
- R11: The offset wraps from FFFF to 0000 hex within 16 bits. The segment is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Redirect: empty the queue and load a new fetch pointer |
| flush_seg | input | 16 | Code segment loaded on redirect |
| flush_off | input | 16 | Fetch offset loaded on redirect |
| bus_req | output | 1 | Code word fetch request |
| bus_addr | output | 20 | Physical fetch address |
| bus_ack | input | 1 | Fetch completes; `bus_data` is valid in this cycle |
| bus_data | input | 16 | Returned code word |
| pop | input | 1 | Execution side takes the head byte |
| byte_out | output | 8 | Head byte of the queue |
| byte_valid | output | 1 | Queue holds at least one byte |
| level | output | 3 | Number of queued bytes |

## Verification
The cycle-level properties are checked on every clock. These cover the occupancy bookkeeping for simultaneous pop and fill, the cap on `level`, the rule that a request starts only with two free slots, the holding of the request and address, how many bytes odd and even fetches write, and the empty queue after a redirect. Other behaviours need a scenario to show them: the byte order across many fetches, the 20-bit address truncation and the 16-bit offset wrap, data dropped from an acknowledge that lands with a redirect, and empty-queue pops that change nothing. The bench shows these by streaming bytes from several start points, with varied bus latency and pop spacing.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int ADDR_W = 20;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;

    function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                    input logic [OFF_W-1:0] off);
        logic [ADDR_W-1:0] seg_part;
        logic [ADDR_W-1:0] off_part;
        seg_part = {seg, 4'b0000};
        off_part = {{(ADDR_W-OFF_W){1'b0}}, off};
        return seg_part + off_part;
    endfunction

endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH = 6,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_lo,
    input  logic [7:0]       push_hi,
    input  logic             pop_take,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] level,
    output logic             not_empty
);

    logic [7:0]       slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] wr_ptr_p1;
    logic [PTR_W-1:0] wr_ptr_p2;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        wr_ptr_p1 = step(wr_ptr);
        wr_ptr_p2 = step(wr_ptr_p1);
    end

    // Byte storage: no reset needed, validity is tracked by count.
    always_ff @(posedge clk) begin
        if (push_n != 2'd0) begin
            slots[wr_ptr] <= push_lo;
        end
        if (push_n == 2'd2) begin
            slots[wr_ptr_p1] <= push_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            unique case (push_n)
                2'd1:    wr_ptr <= wr_ptr_p1;
                2'd2:    wr_ptr <= wr_ptr_p2;
                default: wr_ptr <= wr_ptr;
            endcase
            if (pop_take) begin
                rd_ptr <= step(rd_ptr);
            end
            count <= count + CNT_W'(push_n) - CNT_W'(pop_take);
        end
    end

    always_comb begin
        head      = slots[rd_ptr];
        level     = count;
        not_empty = (count != '0);
    end

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter logic [15:0] RST_SEG = 16'hFFFF,
    parameter logic [15:0] RST_OFF = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [SEG_W-1:0]  flush_seg,
    input  logic [OFF_W-1:0]  flush_off,
    input  logic              room_ok,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        push_n,
    output logic [7:0]        push_lo,
    output logic [7:0]        push_hi
);

    fetch_state_e     state_q;
    fetch_state_e     state_d;
    logic [SEG_W-1:0] seg_q;
    logic [OFF_W-1:0] off_q;
    logic             accept;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: issue, complete, cancel
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_IDLE: if (!flush && room_ok) state_d = FS_WAIT;
            FS_WAIT: if (flush || bus_ack)  state_d = FS_IDLE;
            default: state_d = FS_IDLE;
        endcase
    end

    // Fetch pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= RST_SEG;
            off_q <= RST_OFF;
        end else if (flush) begin
            seg_q <= flush_seg;
            off_q <= flush_off;
        end else if (accept) begin
            off_q <= off_q + (off_q[0] ? OFF_W'(1) : OFF_W'(2));
        end
    end

    // Outputs
    always_comb begin
        bus_req  = (state_q == FS_WAIT);
        bus_addr = phys_addr(seg_q, off_q);
        accept   = bus_req && bus_ack && !flush;
        push_lo  = off_q[0] ? bus_data[15:8] : bus_data[7:0];
        push_hi  = bus_data[15:8];
        if (!accept) begin
            push_n = 2'd0;
        end else if (off_q[0]) begin
            push_n = 2'd1;
        end else begin
            push_n = 2'd2;
        end
    end

endmodule

// File: rtl/pfq_top.sv
module pfq_top
    import pfq_pkg::*;
#(
    parameter int          DEPTH   = 6,
    parameter logic [15:0] RST_SEG = 16'hFFFF,
    parameter logic [15:0] RST_OFF = 16'h0000,
    parameter int          CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [15:0]       flush_seg,
    input  logic [15:0]       flush_off,
    output logic              bus_req,
    output logic [19:0]       bus_addr,
    input  logic              bus_ack,
    input  logic [15:0]       bus_data,
    input  logic              pop,
    output logic [7:0]        byte_out,
    output logic              byte_valid,
    output logic [CNT_W-1:0]  level
);

    logic [1:0] push_n;
    logic [7:0] push_lo;
    logic [7:0] push_hi;
    logic       pop_take;
    logic       room_ok;

    always_comb begin
        room_ok  = (level <= CNT_W'(DEPTH - 2));
        pop_take = pop && byte_valid;
    end

    pfq_fetch #(
        .RST_SEG (RST_SEG),
        .RST_OFF (RST_OFF)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .flush_seg (flush_seg),
        .flush_off (flush_off),
        .room_ok   (room_ok),
        .bus_ack   (bus_ack),
        .bus_data  (bus_data),
        .bus_req   (bus_req),
        .bus_addr  (bus_addr),
        .push_n    (push_n),
        .push_lo   (push_lo),
        .push_hi   (push_hi)
    );

    pfq_store #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (flush),
        .push_n    (push_n),
        .push_lo   (push_lo),
        .push_hi   (push_hi),
        .pop_take  (pop_take),
        .head      (byte_out),
        .level     (level),
        .not_empty (byte_valid)
    );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
    parameter int DEPTH = 6,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic [CNT_W-1:0] level,
    input logic [1:0]       push_n,
    input logic             pop_take,
    input logic             bus_req,
    input logic             bus_ack,
    input logic [19:0]      bus_addr
);

    a_r3_level_cap: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= DEPTH);

    a_r3_issue_room: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> int'(level) <= DEPTH - 2);

    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !flush) |=> (bus_req && $stable(bus_addr)));

    a_r4_even_two: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !flush && !bus_addr[0]) |-> (push_n == 2'd2));

    a_r5_odd_one: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && !flush && bus_addr[0]) |-> (push_n == 2'd1));

    a_r9_level_track: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> int'(level) == int'($past(level)) + int'($past(push_n)) - int'($past(pop_take)));

    a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0 && !bus_req));

endmodule

bind pfq_top pfq_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_pfq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .level    (level),
    .push_n   (push_n),
    .pop_take (pop_take),
    .bus_req  (bus_req),
    .bus_ack  (bus_ack),
    .bus_addr (bus_addr)
);

// File: tb/test_pfq_top.sv
module test_pfq_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        flush;
    logic [15:0] flush_seg;
    logic [15:0] flush_off;
    logic        bus_req;
    logic [19:0] bus_addr;
    logic        bus_ack;
    logic [15:0] bus_data;
    logic        pop;
    logic [7:0]  byte_out;
    logic        byte_valid;
    logic [2:0]  level;

    int n_chk  = 0;
    int n_fail = 0;

    // Responder controls and expectation pointers
    logic        resp_en = 1'b0;
    logic        man_en  = 1'b0;
    logic        man_ack = 1'b0;
    logic [15:0] man_data = 16'h0;
    int          lat = 0;
    logic [15:0] f_seg, f_off;   // next expected fetch
    logic [15:0] c_seg, c_off;   // next expected popped byte

    // Vector table: {seg, off, bytes, latency, pop gap, pad}
    localparam int NV = 5;
    localparam logic [63:0] VEC [NV] = '{
        {16'h1000, 16'h0000, 8'd20, 8'd0, 8'd0, 8'd0},
        {16'h2345, 16'h0011, 8'd15, 8'd2, 8'd1, 8'd0},
        {16'hFFFF, 16'hFFF0, 8'd40, 8'd1, 8'd3, 8'd0},
        {16'h0ABC, 16'hFFFD, 8'd12, 8'd3, 8'd0, 8'd0},
        {16'h7777, 16'h1235, 8'd25, 8'd0, 8'd5, 8'd0}
    };

    always #5 clk = ~clk;

    pfq_top i_pfq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .flush_seg  (flush_seg),
        .flush_off  (flush_off),
        .bus_req    (bus_req),
        .bus_addr   (bus_addr),
        .bus_ack    (bus_ack),
        .bus_data   (bus_data),
        .pop        (pop),
        .byte_out   (byte_out),
        .byte_valid (byte_valid),
        .level      (level)
    );

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        return 20'({s, 4'h0}) + 20'(o);
    endfunction

    function automatic logic [7:0] code_at(input logic [19:0] a);
        return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5A;
    endfunction

    function automatic logic [15:0] word_at(input logic [19:0] a);
        return {code_at(a | 20'h1), code_at(a & ~20'h1)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] next_off(input logic [15:0] o);
        return o + (o[0] ? 16'd1 : 16'd2);
    endfunction

    // Bus responder: reacts just after each falling edge
    initial begin
        int wcnt;
        wcnt = 0;
        bus_ack = 1'b0;
        bus_data = 16'h0;
        forever begin
            @(negedge clk);
            #1;
            if (man_en) begin
                bus_ack  = man_ack;
                bus_data = man_data;
            end else if (resp_en && rst_n && bus_req && !flush) begin
                if (wcnt >= lat) begin
                    // R2 R4 R5 R11: each fetch address follows segment, offset and step rules
                    chk(bus_addr == pa(f_seg, f_off), "R2", "fetch address",
                        int'(bus_addr), int'(pa(f_seg, f_off)));
                    bus_ack  = 1'b1;
                    bus_data = word_at(bus_addr);
                    f_off    = next_off(f_off);
                    wcnt     = 0;
                end else begin
                    bus_ack = 1'b0;
                    wcnt++;
                end
            end else begin
                bus_ack = 1'b0;
                wcnt    = 0;
            end
        end
    end

    task automatic do_flush(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        flush = 1'b1; flush_seg = s; flush_off = o;
        f_seg = s; f_off = o; c_seg = s; c_off = o;
        @(negedge clk);
        flush = 1'b0;
        chk(level == 3'd0 && !bus_req && !byte_valid, "R10", "state after flush",
            {level, bus_req, byte_valid}, 0);
    endtask

    task automatic consume(input int n, input int gap);
        int got, g, w;
        got = 0; g = 0; w = 0;
        while (got < n) begin
            @(negedge clk);
            pop = 1'b0;
            w++;
            if (w > 3000) begin
                chk(1'b0, "R7", "byte stream stalled", got, n);
                break;
            end
            if (g > 0) begin
                g--;
            end else if (byte_valid) begin
                chk(byte_out == code_at(pa(c_seg, c_off)), "R7", "popped byte",
                    int'(byte_out), int'(code_at(pa(c_seg, c_off))));
                c_off = c_off + 16'd1;
                pop = 1'b1;
                got++;
                g = gap;
            end
        end
        @(negedge clk);
        pop = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; flush = 1'b0; flush_seg = 16'h0; flush_off = 16'h0; pop = 1'b0;
        f_seg = 16'hFFFF; f_off = 16'h0000; c_seg = 16'hFFFF; c_off = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: outputs held quiet during reset
        chk(level == 3'd0 && !byte_valid && !bus_req, "R1", "reset outputs",
            {level, byte_valid, bus_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(bus_req == 1'b1, "R1", "request after reset", int'(bus_req), 1);
        chk(bus_addr == 20'hFFFF0, "R1", "reset fetch address", int'(bus_addr), 'hFFFF0);

        // R8: popping an empty queue changes nothing
        pop = 1'b1;
        repeat (3) @(negedge clk);
        chk(!byte_valid && level == 3'd0, "R8", "empty pop", {level, byte_valid}, 0);
        pop = 1'b0;

        // R3: queue fills to the depth and stops requesting
        resp_en = 1'b1;
        lat = 0;
        repeat (20) @(negedge clk);
        chk(level == 3'd6, "R3", "full level", int'(level), 6);
        chk(!bus_req, "R3", "no request when full", int'(bus_req), 0);
        consume(6, 0);

        // R5: odd start writes one byte, then stops with one slot free
        resp_en = 1'b0;
        do_flush(16'h0100, 16'h0003);
        resp_en = 1'b1;
        begin
            int w;
            w = 0;
            while (level == 3'd0 && w < 50) begin @(negedge clk); w++; end
        end
        chk(level == 3'd1, "R5", "odd first fetch level", int'(level), 1);
        repeat (20) @(negedge clk);
        chk(level == 3'd5, "R3", "one slot free, no fetch", int'(level), 5);
        chk(!bus_req, "R3", "no request with one slot", int'(bus_req), 0);
        consume(5, 0);

        // R9: pop and fill in the same cycle
        resp_en = 1'b0;
        do_flush(16'h0200, 16'h0000);
        resp_en = 1'b1;
        begin
            int w;
            w = 0;
            while (level != 3'd4 && w < 50) begin @(negedge clk); w++; end
            man_en = 1'b1; man_ack = 1'b0;
        end
        repeat (2) @(negedge clk);
        chk(bus_req && level == 3'd4, "R9", "setup level 4 with request",
            {level, bus_req}, 'h9);
        chk(bus_addr == pa(f_seg, f_off), "R4", "manual fetch address",
            int'(bus_addr), int'(pa(f_seg, f_off)));
        chk(byte_out == code_at(pa(c_seg, c_off)), "R7", "head before pop",
            int'(byte_out), int'(code_at(pa(c_seg, c_off))));
        man_ack = 1'b1;
        man_data = word_at(bus_addr);
        f_off = next_off(f_off);
        c_off = c_off + 16'd1;
        pop = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;
        pop = 1'b0;
        chk(level == 3'd5, "R9", "level after pop plus fill", int'(level), 5);
        man_en = 1'b0;
        consume(10, 0);

        // R10: acknowledge landing with a flush is discarded
        resp_en = 1'b0;
        do_flush(16'h0500, 16'h0010);
        begin
            int w;
            w = 0;
            while (!bus_req && w < 50) begin @(negedge clk); w++; end
        end
        flush = 1'b1; flush_seg = 16'h0600; flush_off = 16'h0020;
        f_seg = 16'h0600; f_off = 16'h0020; c_seg = 16'h0600; c_off = 16'h0020;
        man_en = 1'b1; man_ack = 1'b1; man_data = 16'hDEAD;
        @(negedge clk);
        flush = 1'b0; man_ack = 1'b0; man_en = 1'b0;
        chk(level == 3'd0 && !byte_valid, "R10", "data dropped on flush",
            {level, byte_valid}, 0);
        resp_en = 1'b1;
        consume(8, 1);

        // Vector table: R2, R7 and R11 across start points, latencies, pop spacing
        for (int v = 0; v < NV; v++) begin
            resp_en = 1'b0;
            lat = int'(VEC[v][23:16]);
            do_flush(VEC[v][63:48], VEC[v][47:32]);
            resp_en = 1'b1;
            consume(int'(VEC[v][31:24]), int'(VEC[v][15:8]));
        end
        // R11: the wrap vectors left the segment unchanged
        chk(f_seg == 16'h7777, "R11", "segment kept", int'(f_seg), 'h7777);

        resp_en = 1'b0;
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule